// File: doc/BRIEF.md
# SDRAM Low-Power Sequencer

This block is the part of an SDRAM controller that decides when the attached memory drops into a low-power state and how it comes back out. While it owns the command pins it drives clock-enable and the chip-select, row-strobe, column-strobe and write-enable lines itself. It tells the access path through a ready flag when the device can take commands again. A 2-bit mode input picks one of three states: self-refresh, power-down with refreshes issued by the controller, or deep power-down. Deep power-down is for mobile-type parts only, and the memory contents are lost once it is entered. Entry waits until no access is pending. Self-refresh and power-down also wait for a programmable run of idle cycles.

A refresh-interval counter keeps the array refreshed while the block is awake or in power-down. A refresh that comes due while the ready state is idle goes out at once. In power-down the block wakes for one cycle, runs a full precharge / auto-refresh sequence, and sinks back into power-down. The precharge spacing and the refresh cycle time are inputs counted in clock cycles.

Command encoding on {cs_n, ras_n, cas_n, we_n}: NOP = 0111, precharge-all = 0010, auto-refresh = 0001, deep power-down = 0110. Self-refresh is the auto-refresh code issued with clock-enable low. Power-down is a NOP with clock-enable low. t_rp and t_rc must each be at least 2, and the refresh interval at least 1.

Top module: `sdram_lp_seq`

## Requirements
- R1: The mode input selects the behaviour: 0 = never enter a low-power state, 1 = self-refresh, 2 = power-down, 3 = deep power-down.
- R2: While access_req is high in the ready state, no low-power entry and no refresh starts. clock-enable stays high and ready stays high.
- R3: With a timeout of T, self-refresh or power-down entry begins on the (T+1)-th clock edge after access_req goes low. T = 0 means the first edge. Deep power-down entry ignores the timeout and starts on the first edge.
- R4: Self-refresh entry is a precharge-all, then t_rp cycles later the self-refresh code with clock-enable low in that same cycle. After that, clock-enable stays low and only NOPs appear until an access request.
- R5: Power-down entry drives clock-enable low with a NOP. When a refresh falls due in power-down, the block gives one NOP cycle with clock-enable high, then a precharge-all, then an auto-refresh t_rp cycles later. It returns to clock-enable low t_rc cycles after the auto-refresh. ready stays low throughout.
- R6: An access request in self-refresh raises clock-enable on the next cycle and gives t_rc cycles of NOPs; ready rises in the cycle after them. An access request in power-down gives one NOP cycle with clock-enable high, and ready rises in the next cycle.
- R7: Deep power-down entry is a precharge-all, then t_rp cycles later the deep power-down code with clock-enable low. An access request then raises clock-enable and sets reinit_req. ready stays low and reinit_req stays high until reset.
- R8: A refresh falls due every ref_interval cycles while the counter runs. In the idle ready state it starts with a precharge-all at once. The counter is cleared and held in self-refresh and deep power-down, so no auto-refresh is issued there.
- R9: ready drops at the precharge. The auto-refresh follows t_rp cycles after the precharge, and ready returns t_rc cycles after the auto-refresh. Both spacings follow the t_rp and t_rc inputs.
- R10: After reset the block is in the ready state: clock-enable high, NOP on the command lines, ready high, reinit_req low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_mode | input | 2 | Low-power mode select (R1 encoding) |
| idle_limit | input | CW | Idle cycles before self-refresh or power-down entry |
| ref_interval | input | CW | Cycles between refreshes |
| access_req | input | 1 | An access is pending for the SDRAM |
| t_rp | input | TW | Precharge-to-command spacing in cycles (at least 2) |
| t_rc | input | TW | Refresh cycle time in cycles (at least 2) |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| lp_ready | output | 1 | Device can accept access commands |
| reinit_req | output | 1 | Contents lost, host must re-initialize |

## Verification
The bench builds the block with its default widths: 16-bit counters for the timeout and interval, and 4-bit spacing inputs. It drives t_rp/t_rc as both 3/8 and 4/5, so the precharge and refresh spacings can be seen to follow the inputs rather than constants. Refresh intervals of 10 and 20 make several refreshes fall due within a short trace, both in power-down and in the ready state. An interval of 1000 keeps refresh out of the entry-timing runs. Timeouts from 0 to 9 cover immediate entry, delayed entry, and deep power-down ignoring the timeout.

// File: rtl/sdlp_pkg.sv
package sdlp_pkg;

    typedef enum logic [1:0] {
        LP_OFF   = 2'd0,
        LP_SELF  = 2'd1,
        LP_PDOWN = 2'd2,
        LP_DEEP  = 2'd3
    } lp_mode_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sd_cmd_t;

    localparam sd_cmd_t CMD_NOP  = 4'b0111;
    localparam sd_cmd_t CMD_PRE  = 4'b0010;
    localparam sd_cmd_t CMD_AREF = 4'b0001;
    localparam sd_cmd_t CMD_DPD  = 4'b0110;

    typedef enum logic [3:0] {
        ST_ACT, ST_PRE, ST_TRP, ST_AREF, ST_TRC,
        ST_SREF, ST_SR, ST_SRX,
        ST_PD, ST_PDX,
        ST_DPDE, ST_DPD, ST_LOST
    } seq_state_e;

    typedef enum logic [1:0] {
        GOAL_REF, GOAL_SELF, GOAL_DEEP
    } goal_e;

    typedef struct packed {
        logic    cke;
        sd_cmd_t cmd;
        logic    ready;
        logic    reinit;
    } pin_drive_t;

    // Pin levels for each sequencer state
    function automatic pin_drive_t drive_for(seq_state_e s);
        pin_drive_t d;
        d.cke    = 1'b1;
        d.cmd    = CMD_NOP;
        d.ready  = 1'b0;
        d.reinit = 1'b0;
        case (s)
            ST_ACT:  d.ready = 1'b1;
            ST_PRE:  d.cmd   = CMD_PRE;
            ST_AREF: d.cmd   = CMD_AREF;
            ST_SREF: begin d.cke = 1'b0; d.cmd = CMD_AREF; end
            ST_SR:   d.cke = 1'b0;
            ST_PD:   d.cke = 1'b0;
            ST_DPDE: begin d.cke = 1'b0; d.cmd = CMD_DPD; end
            ST_DPD:  d.cke = 1'b0;
            ST_LOST: d.reinit = 1'b1;
            default: ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/sdlp_idle_timer.sv
module sdlp_idle_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear_i,
    input  logic [CW-1:0] limit_i,
    output logic          expired_o
);
    localparam logic [CW-1:0] CNT_MAX = '1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i)
            cnt_q <= '0;
        else if (cnt_q != CNT_MAX)
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired_o = (cnt_q >= limit_i);

    // R3
    idle_clr_chk: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (cnt_q == '0));

endmodule

// File: rtl/sdlp_refresh_timer.sv
module sdlp_refresh_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold_i,
    input  logic          ack_i,
    input  logic [CW-1:0] interval_i,
    output logic          pend_o
);
    logic [CW-1:0] cnt_q;
    logic          pend_q;
    logic          wrap;

    assign wrap = (cnt_q >= (interval_i - 1'b1));

    always_ff @(posedge clk) begin
        if (rst || hold_i) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            cnt_q  <= wrap ? '0 : cnt_q + 1'b1;
            pend_q <= wrap ? 1'b1 : (ack_i ? 1'b0 : pend_q);
        end
    end

    assign pend_o = pend_q;

    // R8
    hold_clears_chk: assert property (@(posedge clk) disable iff (rst)
        hold_i |=> !pend_o);

endmodule

// File: rtl/sdlp_seq.sv
module sdlp_seq
    import sdlp_pkg::*;
#(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  lp_mode_e      mode_i,
    input  logic          access_i,
    input  logic          idle_exp_i,
    input  logic          ref_pend_i,
    input  logic [TW-1:0] t_rp_i,
    input  logic [TW-1:0] t_rc_i,
    output logic          cke_o,
    output sd_cmd_t       cmd_o,
    output logic          ready_o,
    output logic          reinit_o,
    output logic          ref_ack_o,
    output logic          idle_clr_o,
    output logic          ref_hold_o
);
    localparam logic [TW-1:0] ONE = TW'(1);
    localparam logic [TW-1:0] TWO = TW'(2);

    seq_state_e    state_q, state_d;
    goal_e         goal_q, goal_d;
    logic          pd_ret_q, pd_ret_d;
    logic [TW-1:0] wait_q, wait_d;
    pin_drive_t    drv;

    always_comb begin
        state_d  = state_q;
        goal_d   = goal_q;
        pd_ret_d = pd_ret_q;
        wait_d   = wait_q;
        case (state_q)
            ST_ACT: begin
                if (!access_i) begin
                    if (ref_pend_i) begin
                        state_d  = ST_PRE;
                        goal_d   = GOAL_REF;
                        pd_ret_d = 1'b0;
                    end else begin
                        case (mode_i)
                            LP_SELF:  if (idle_exp_i) begin
                                          state_d = ST_PRE;
                                          goal_d  = GOAL_SELF;
                                      end
                            LP_PDOWN: if (idle_exp_i) state_d = ST_PD;
                            LP_DEEP:  begin
                                          state_d = ST_PRE;
                                          goal_d  = GOAL_DEEP;
                                      end
                            default:  ;
                        endcase
                    end
                end
            end
            ST_PRE: begin
                wait_d  = t_rp_i - TWO;
                state_d = ST_TRP;
            end
            ST_TRP: begin
                if (wait_q == '0) begin
                    case (goal_q)
                        GOAL_REF:  state_d = ST_AREF;
                        GOAL_SELF: state_d = ST_SREF;
                        default:   state_d = ST_DPDE;
                    endcase
                end else begin
                    wait_d = wait_q - ONE;
                end
            end
            ST_AREF: begin
                wait_d  = t_rc_i - TWO;
                state_d = ST_TRC;
            end
            ST_TRC: begin
                if (wait_q == '0) begin
                    state_d  = (pd_ret_q && !access_i) ? ST_PD : ST_ACT;
                    pd_ret_d = 1'b0;
                end else begin
                    wait_d = wait_q - ONE;
                end
            end
            ST_SREF: state_d = ST_SR;
            ST_SR: begin
                if (access_i) begin
                    state_d = ST_SRX;
                    wait_d  = t_rc_i - ONE;
                end
            end
            ST_SRX: begin
                if (wait_q == '0) state_d = ST_ACT;
                else              wait_d  = wait_q - ONE;
            end
            ST_PD: begin
                if (access_i) begin
                    state_d  = ST_PDX;
                    pd_ret_d = 1'b0;
                end else if (ref_pend_i) begin
                    state_d  = ST_PDX;
                    pd_ret_d = 1'b1;
                end
            end
            ST_PDX: begin
                if (pd_ret_q) begin
                    state_d = ST_PRE;
                    goal_d  = GOAL_REF;
                end else begin
                    state_d = ST_ACT;
                end
            end
            ST_DPDE: state_d = ST_DPD;
            ST_DPD:  if (access_i) state_d = ST_LOST;
            ST_LOST: state_d = ST_LOST;
            default: state_d = ST_ACT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_ACT;
            goal_q   <= GOAL_REF;
            pd_ret_q <= 1'b0;
            wait_q   <= '0;
        end else begin
            state_q  <= state_d;
            goal_q   <= goal_d;
            pd_ret_q <= pd_ret_d;
            wait_q   <= wait_d;
        end
    end

    assign drv        = drive_for(state_q);
    assign cke_o      = drv.cke;
    assign cmd_o      = drv.cmd;
    assign ready_o    = drv.ready;
    assign reinit_o   = drv.reinit;
    assign ref_ack_o  = (state_q == ST_AREF);
    assign idle_clr_o = (state_q != ST_ACT) || access_i;
    assign ref_hold_o = (state_q == ST_SREF) || (state_q == ST_SR) ||
                        (state_q == ST_DPDE) || (state_q == ST_DPD) ||
                        (state_q == ST_LOST);

    // R2
    busy_stay_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ACT && access_i) |=> (state_q == ST_ACT));

    // R4
    sref_order_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SREF) |-> ($past(state_q) == ST_TRP));

    // R5
    pd_wake_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PD && !access_i && ref_pend_i) |=> (state_q == ST_PDX && cke_o));

    // R6
    sr_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SR && access_i) |=> (cke_o && !ready_o));

    // R7
    lost_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        reinit_o |=> (reinit_o && !ready_o));

endmodule

// File: rtl/sdram_lp_seq.sv
module sdram_lp_seq
    import sdlp_pkg::*;
#(
    parameter int CW = 16,
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    lp_mode,
    input  logic [CW-1:0] idle_limit,
    input  logic [CW-1:0] ref_interval,
    input  logic          access_req,
    input  logic [TW-1:0] t_rp,
    input  logic [TW-1:0] t_rc,
    output logic          sd_cke,
    output logic          sd_cs_n,
    output logic          sd_ras_n,
    output logic          sd_cas_n,
    output logic          sd_we_n,
    output logic          lp_ready,
    output logic          reinit_req
);
    logic    idle_exp, idle_clr;
    logic    ref_pend, ref_ack, ref_hold;
    sd_cmd_t cmd;

    sdlp_idle_timer #(.CW(CW)) u_idle (
        .clk       (clk),
        .rst       (rst),
        .clear_i   (idle_clr),
        .limit_i   (idle_limit),
        .expired_o (idle_exp)
    );

    sdlp_refresh_timer #(.CW(CW)) u_ref (
        .clk        (clk),
        .rst        (rst),
        .hold_i     (ref_hold),
        .ack_i      (ref_ack),
        .interval_i (ref_interval),
        .pend_o     (ref_pend)
    );

    sdlp_seq #(.TW(TW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (lp_mode_e'(lp_mode)),
        .access_i   (access_req),
        .idle_exp_i (idle_exp),
        .ref_pend_i (ref_pend),
        .t_rp_i     (t_rp),
        .t_rc_i     (t_rc),
        .cke_o      (sd_cke),
        .cmd_o      (cmd),
        .ready_o    (lp_ready),
        .reinit_o   (reinit_req),
        .ref_ack_o  (ref_ack),
        .idle_clr_o (idle_clr),
        .ref_hold_o (ref_hold)
    );

    assign sd_cs_n  = cmd.cs_n;
    assign sd_ras_n = cmd.ras_n;
    assign sd_cas_n = cmd.cas_n;
    assign sd_we_n  = cmd.we_n;

endmodule

// File: tb/tb_sdram_lp_seq.sv
module tb_sdram_lp_seq;
    localparam int CW = 16;
    localparam int TW = 4;

    // {cke, cs_n, ras_n, cas_n, we_n}
    localparam logic [4:0] P_NOP  = 5'b10111;
    localparam logic [4:0] P_PRE  = 5'b10010;
    localparam logic [4:0] P_AREF = 5'b10001;
    localparam logic [4:0] P_SREF = 5'b00001;
    localparam logic [4:0] P_PD   = 5'b00111;

    // {mode, timeout, expected entry cycle (0 = never), expected pins}
    localparam logic [20:0] VEC [7] = '{
        {2'd1, 6'd0, 8'd4, 5'b00001},
        {2'd1, 6'd5, 8'd9, 5'b00001},
        {2'd2, 6'd0, 8'd1, 5'b00111},
        {2'd2, 6'd7, 8'd8, 5'b00111},
        {2'd3, 6'd0, 8'd4, 5'b00110},
        {2'd3, 6'd9, 8'd4, 5'b00110},
        {2'd0, 6'd0, 8'd0, 5'b00000}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    lp_mode = 2'd0;
    logic [CW-1:0] idle_limit = '0;
    logic [CW-1:0] ref_interval = 16'd1000;
    logic          access_req = 1'b1;
    logic [TW-1:0] t_rp = 4'd3;
    logic [TW-1:0] t_rc = 4'd8;
    logic          sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, lp_ready, reinit_req;

    int checks = 0;
    int fails  = 0;
    logic [4:0] tr [0:79];
    logic       rd [0:79];
    logic       rn [0:79];

    sdram_lp_seq #(.CW(CW), .TW(TW)) dut (
        .clk(clk), .rst(rst), .lp_mode(lp_mode), .idle_limit(idle_limit),
        .ref_interval(ref_interval), .access_req(access_req), .t_rp(t_rp), .t_rc(t_rc),
        .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .lp_ready(lp_ready), .reinit_req(reinit_req)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic start(input logic [1:0] m, input int tmo, input int intv,
                         input int rp, input int rc);
        rst = 1'b1; access_req = 1'b1;
        lp_mode = m; idle_limit = CW'(tmo); ref_interval = CW'(intv);
        t_rp = TW'(rp); t_rc = TW'(rc);
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic run_trace(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            tr[i] = {sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            rd[i] = lp_ready;
            rn[i] = reinit_req;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int cnt, a1, a2, n;

        // R10 reset state
        start(2'd0, 0, 1000, 3, 8);
        chk(sd_cke == 1'b1, "R10 cke", sd_cke, 1);
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R10 cmd",
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 7);
        chk(lp_ready == 1'b1, "R10 ready", lp_ready, 1);
        chk(reinit_req == 1'b0, "R10 reinit", reinit_req, 0);

        // R2 pending access blocks entry
        start(2'd2, 0, 1000, 3, 8);
        run_trace(20);
        cnt = 0;
        for (int i = 0; i < 20; i++) if (tr[i] != P_NOP || !rd[i]) cnt++;
        chk(cnt == 0, "R2 busy cycles disturbed", cnt, 0);

        // R1 R3 R4 R7 entry table
        for (int v = 0; v < 7; v++) begin
            start(VEC[v][20:19], int'(VEC[v][18:13]), 1000, 3, 8);
            access_req = 1'b0;
            run_trace(40);
            n = 0;
            for (int i = 39; i >= 0; i--) if (tr[i][4] == 1'b0) n = i + 1;
            chk(n == int'(VEC[v][12:5]), "R3 entry cycle", n, int'(VEC[v][12:5]));
            if (n != 0)
                chk(tr[n-1] == VEC[v][4:0], "R1 entry pins", tr[n-1], VEC[v][4:0]);
            if (n > 3 && (VEC[v][20:19] == 2'd1 || VEC[v][20:19] == 2'd3))
                chk(tr[n-4] == P_PRE, "R4 R7 precharge before entry", tr[n-4], P_PRE);
        end

        // R4 R8 self-refresh holds, R6 exit
        start(2'd1, 0, 1000, 3, 8);
        access_req = 1'b0;
        run_trace(4);
        ref_interval = 16'd10;
        run_trace(40);
        cnt = 0;
        for (int i = 0; i < 40; i++) if (tr[i] != P_PD) cnt++;
        chk(cnt == 0, "R4 R8 self-refresh quiet", cnt, 0);
        access_req = 1'b1;
        run_trace(10);
        chk(tr[0] == P_NOP, "R6 sr exit cke", tr[0], P_NOP);
        chk(rd[7] == 1'b0, "R6 sr exit ready early", rd[7], 0);
        chk(rd[8] == 1'b1, "R6 sr exit ready", rd[8], 1);

        // R5 refresh from power-down
        start(2'd2, 0, 20, 3, 8);
        access_req = 1'b0;
        run_trace(70);
        a1 = -1;
        for (int i = 69; i >= 5; i--) if (tr[i] == P_AREF) a1 = i;
        chk(a1 >= 5 && a1 <= 60, "R5 auto-refresh seen", a1, 25);
        if (a1 >= 5 && a1 <= 60) begin
            chk(tr[a1-5] == P_PD && tr[a1-4] == P_NOP && tr[a1-3] == P_PRE,
                "R5 wake sequence", {tr[a1-5], tr[a1-4], tr[a1-3]},
                {P_PD, P_NOP, P_PRE});
            chk(tr[a1+8] == P_PD && tr[a1+7] == P_NOP, "R5 re-entry",
                tr[a1+8], P_PD);
        end
        cnt = 0;
        for (int i = 0; i < 70; i++) if (rd[i]) cnt++;
        chk(cnt == 0, "R5 ready stays low", cnt, 0);

        // R6 power-down exit
        start(2'd2, 0, 1000, 3, 8);
        access_req = 1'b0;
        run_trace(5);
        access_req = 1'b1;
        run_trace(3);
        chk(tr[0] == P_NOP && rd[0] == 1'b0, "R6 pd exit nop", tr[0], P_NOP);
        chk(rd[1] == 1'b1, "R6 pd exit ready", rd[1], 1);

        // R7 deep power-down exit
        start(2'd3, 0, 1000, 3, 8);
        access_req = 1'b0;
        run_trace(10);
        access_req = 1'b1;
        run_trace(20);
        chk(tr[0][4] == 1'b1 && rn[0] == 1'b1, "R7 reinit raised",
            {tr[0][4], rn[0]}, 3);
        cnt = 0;
        for (int i = 0; i < 20; i++) if (rd[i] || !rn[i]) cnt++;
        chk(cnt == 0, "R7 no ready after deep exit", cnt, 0);

        // R8 R9 periodic refresh in ready state, t_rp=4 t_rc=5
        start(2'd0, 0, 20, 4, 5);
        access_req = 1'b0;
        run_trace(80);
        a1 = -1; a2 = -1;
        for (int i = 79; i >= 4; i--) if (tr[i] == P_AREF) a1 = i;
        if (a1 >= 0)
            for (int i = 79; i > a1; i--) if (tr[i] == P_AREF) a2 = i;
        chk(a1 >= 4 && a2 > a1 && (a2 - a1) == 20, "R8 refresh period", a2 - a1, 20);
        if (a1 >= 4 && a1 <= 70) begin
            chk(tr[a1-4] == P_PRE, "R9 precharge spacing", tr[a1-4], P_PRE);
            chk(rd[a1+4] == 1'b0 && rd[a1+5] == 1'b1, "R9 ready after t_rc",
                {rd[a1+4], rd[a1+5]}, 1);
        end
        cnt = 0;
        for (int i = 0; i < 80; i++) if (!tr[i][4]) cnt++;
        chk(cnt == 0, "R1 mode 0 never enters", cnt, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule